// File: doc/BRIEF.md
# Wide-to-Narrow Register Bus Width Adapter

This block puts a bank of 16-bit registers behind a 32-bit memory-mapped master port. The master issues byte addresses on 4-byte boundaries. The adapter subtracts a base address and drops the two low bits to get a master word index. It then drives a narrow register interface whose read data arrives one cycle after the request. The register bank is part of the block, so every register can be observed through master reads.

A static mode input selects one of two mappings. In native mode each master word covers one register: the register is returned in the low half of the read word and the upper half reads as zero. In dynamic sizing mode each master word covers two registers that are accessed one after the other, even-numbered register first. The adapter holds `m_waitrequest` high until the access sequence is complete. Byte enables gate the register writes one byte at a time. A write whose byte enables select nothing leaves the bank untouched.

Top module: `bus_width_adapter`

## Requirements
- R1: The word index is W = (m_address - BASE_ADDR) / 4. Addresses are aligned to 4 bytes. An address below BASE_ADDR is out of range.
- R2: Native mode (dyn_mode=0) read of word W with W < NUM_REGS returns {16'h0000, reg[W]}.
- R3: A native mode write to word W updates reg[W]. byteenable[0] enables bits 7:0 from writedata[7:0] and byteenable[1] enables bits 15:8 from writedata[15:8]. writedata[31:16] and byteenable[3:2] have no effect.
- R4: Dynamic mode (dyn_mode=1) read of word W returns reg[2W] in bits 15:0 and reg[2W+1] in bits 31:16. Each half whose register index is NUM_REGS or more reads as zero.
- R5: A dynamic mode write to word W updates reg[2W] from writedata[15:0] under byteenable[1:0], and reg[2W+1] from writedata[31:16] under byteenable[3:2]. Each byte lane is enabled separately.
- R6: m_waitrequest is high from the first cycle of a request. It stays high for exactly 2 cycles in native mode and 3 cycles in dynamic mode, then goes low for one cycle to complete the transfer.
- R7: A write with byteenable = 4'b0000 completes normally and leaves every register unchanged, in both modes.
- R8: A register index at or beyond NUM_REGS, or an address below the base, reads as zero and ignores writes.
- R9: Byte enables have no effect on reads. The full 32-bit word is returned even when byteenable is 4'b0000.
- R10: After reset every register is zero, and m_waitrequest is low while no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dyn_mode | input | 1 | 0: native mapping, 1: dynamic sizing mapping; static during a transfer |
| m_address | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_writedata | input | 32 | Master write data |
| m_byteenable | input | 4 | Master byte lane enables |
| m_readdata | output | 32 | Read data, valid when m_waitrequest is low during a read |
| m_waitrequest | output | 1 | Stall; the transfer completes on the edge where it is low |

## Verification
The assertions rely on the master never raising read and write together. They also rely on the master holding its address and command steady while m_waitrequest is high, and on dyn_mode changing only between transfers. The bench drives every request from a task that sets all master inputs at once and holds them until it sees m_waitrequest low. It then idles one cycle before the next request, and it changes the mode only in that idle gap. Random addresses stay on 4-byte boundaries but cover words below the base, words inside the range and words past its end.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
   localparam int WIDE_W   = 32;
   localparam int NARROW_W = 16;
   localparam int LANES    = NARROW_W / 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HIGH = 2'd1,
      ST_CAP  = 2'd2,
      ST_ACK  = 2'd3
   } bwa_state_t;
endpackage

// File: rtl/bwa_decode.sv
module bwa_decode #(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 16'h0400,
   parameter int NUM_REGS  = 11,
   parameter int IDX_W     = 4
) (
   input  logic              dyn_mode,
   input  logic [ADDR_W-1:0] address,
   output logic [IDX_W-1:0]  idx_half [2],
   output logic              ok_half  [2]
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   logic              below;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] word;

   assign below  = address < BASE;
   assign offset = address - BASE;
   assign word   = offset >> 2;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [ADDR_W-1:0] full_idx;
      always_comb begin
         if (dyn_mode) full_idx = (word << 1) + ADDR_W'(h);
         else          full_idx = word;
      end
      assign ok_half[h]  = !below && (full_idx < ADDR_W'(NUM_REGS));
      assign idx_half[h] = full_idx[IDX_W-1:0];
   end
endmodule

// File: rtl/bwa_regfile.sv
module bwa_regfile import bwa_pkg::*; #(
   parameter int NUM_REGS = 11,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    idx,
   input  logic [NARROW_W-1:0] wr_data,
   input  logic [LANES-1:0]    wr_mask,
   output logic [NARROW_W-1:0] rd_data
);
   logic [NUM_REGS*NARROW_W-1:0] store;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store[r*NARROW_W + b*8 +: 8] <= 8'h00;
            else if (wr_en && idx == IDX_W'(r) && wr_mask[b])
               store[r*NARROW_W + b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en && int'(idx) < NUM_REGS)
         rd_data <= store[int'(idx)*NARROW_W +: NARROW_W];
   end

   // R7: the sequencer never issues an empty write
   a_r7_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_mask != '0));
   // R8: only in-range registers are touched
   a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |-> (int'(idx) < NUM_REGS));
   // R3: the bank holds its contents when no write is issued
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(store));
endmodule

// File: rtl/bwa_seq.sv
module bwa_seq import bwa_pkg::*; #(
   parameter int IDX_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dyn_mode,
   input  logic                m_read,
   input  logic                m_write,
   input  logic [WIDE_W-1:0]   m_writedata,
   input  logic [3:0]          m_byteenable,
   input  logic [IDX_W-1:0]    idx_half [2],
   input  logic                ok_half  [2],
   input  logic [NARROW_W-1:0] s_rdata,
   output logic                s_rd,
   output logic                s_wr,
   output logic [IDX_W-1:0]    s_idx,
   output logic [NARROW_W-1:0] s_wdata,
   output logic [LANES-1:0]    s_mask,
   output logic [WIDE_W-1:0]   m_readdata,
   output logic                m_waitrequest
);
   bwa_state_t st_q, st_d;
   logic req, issue, use_hi, half_ok, pend_q;
   logic [NARROW_W-1:0] lo_q, hi_q, got;

   assign req     = m_read || m_write;
   assign use_hi  = (st_q == ST_HIGH);
   assign issue   = (st_q == ST_IDLE && req) || use_hi;
   assign half_ok = use_hi ? ok_half[1] : ok_half[0];
   assign s_idx   = use_hi ? idx_half[1] : idx_half[0];
   assign s_mask  = use_hi ? m_byteenable[3:2] : m_byteenable[1:0];
   assign s_wdata = use_hi ? m_writedata[31:16] : m_writedata[15:0];
   assign s_rd    = issue && m_read && half_ok;
   assign s_wr    = issue && m_write && half_ok && (s_mask != '0);
   assign got     = pend_q ? s_rdata : '0;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req) st_d = dyn_mode ? ST_HIGH : ST_CAP;
         ST_HIGH: st_d = ST_CAP;
         ST_CAP:  st_d = ST_ACK;
         ST_ACK:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         st_q   <= st_d;
         pend_q <= s_rd;
         if (st_q == ST_HIGH) lo_q <= got;
         if (st_q == ST_CAP) begin
            if (dyn_mode) hi_q <= got;
            else begin
               lo_q <= got;
               hi_q <= '0;
            end
         end
      end
   end

   assign m_readdata    = {hi_q, lo_q};
   assign m_waitrequest = req && (st_q != ST_ACK);

   // R6: a new request stalls in its first cycle
   a_r6_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && req) |-> m_waitrequest);
   // R6: the mode is static for the duration of a transfer
   a_r6_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |-> $stable(dyn_mode));
   // R4: the high half is only ever visited in dynamic mode
   a_r4_high_dyn: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH) |-> dyn_mode);
   // R6: the transfer completes straight after the capture cycle
   a_r6_ack_follows_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CAP) |=> (st_q == ST_ACK));
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter import bwa_pkg::*; #(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 16'h0400,
   parameter int NUM_REGS  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dyn_mode,
   input  logic [ADDR_W-1:0] m_address,
   input  logic              m_read,
   input  logic              m_write,
   input  logic [31:0]       m_writedata,
   input  logic [3:0]        m_byteenable,
   output logic [31:0]       m_readdata,
   output logic              m_waitrequest
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   initial begin : p_param_chk
      assert (NUM_REGS >= 2) else $error("NUM_REGS must be at least 2");
      assert (BASE_ADDR % 4 == 0) else $error("BASE_ADDR must be 4-byte aligned");
      assert (ADDR_W >= 4 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (BASE_ADDR < (1 << ADDR_W)) else $error("BASE_ADDR exceeds ADDR_W");
   end

   logic [IDX_W-1:0]    idx_half [2];
   logic                ok_half  [2];
   logic                s_rd, s_wr;
   logic [IDX_W-1:0]    s_idx;
   logic [NARROW_W-1:0] s_wdata, s_rdata;
   logic [LANES-1:0]    s_mask;

   bwa_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_decode (
      .dyn_mode (dyn_mode),
      .address  (m_address),
      .idx_half (idx_half),
      .ok_half  (ok_half)
   );

   bwa_seq #(.IDX_W(IDX_W)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .dyn_mode      (dyn_mode),
      .m_read        (m_read),
      .m_write       (m_write),
      .m_writedata   (m_writedata),
      .m_byteenable  (m_byteenable),
      .idx_half      (idx_half),
      .ok_half       (ok_half),
      .s_rdata       (s_rdata),
      .s_rd          (s_rd),
      .s_wr          (s_wr),
      .s_idx         (s_idx),
      .s_wdata       (s_wdata),
      .s_mask        (s_mask),
      .m_readdata    (m_readdata),
      .m_waitrequest (m_waitrequest)
   );

   bwa_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (s_rd),
      .wr_en   (s_wr),
      .idx     (s_idx),
      .wr_data (s_wdata),
      .wr_mask (s_mask),
      .rd_data (s_rdata)
   );

   // R1: the master never reads and writes at once
   a_r1_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_read && m_write));
   // R1: the master holds its request while stalled
   a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      m_waitrequest |=> ($stable(m_address) && $stable(m_read) && $stable(m_write)));
   // R2: native reads return a zero upper half
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && !m_waitrequest && !dyn_mode) |-> (m_readdata[31:16] == 16'h0000));
   // R10: no stall without a request
   a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_read && !m_write) |-> !m_waitrequest);
endmodule

// File: tb/test_bus_width_adapter.sv
`timescale 1ns/1ps
module test_bus_width_adapter;
   localparam int ADDR_W   = 16;
   localparam int BASE     = 16'h0400;
   localparam int NREGS    = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dyn_mode = 1'b0;
   logic [ADDR_W-1:0] m_address = '0;
   logic        m_read = 1'b0, m_write = 1'b0;
   logic [31:0] m_writedata = '0;
   logic [3:0]  m_byteenable = '0;
   logic [31:0] m_readdata;
   logic        m_waitrequest;

   int checks = 0, failures = 0;
   logic [15:0] model [NREGS];

   always #2 clk = ~clk;

   bus_width_adapter #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .NUM_REGS(NREGS)) i_bus_width_adapter (
      .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .m_address(m_address),
      .m_read(m_read), .m_write(m_write), .m_writedata(m_writedata),
      .m_byteenable(m_byteenable), .m_readdata(m_readdata), .m_waitrequest(m_waitrequest)
   );

   function automatic int reg_index(input logic dyn, input int addr, input int half);
      int w;
      if (addr < BASE) return -1;
      w = (addr - BASE) / 4;
      return dyn ? 2 * w + half : w;
   endfunction

   function automatic logic [15:0] model_get(input int idx);
      if (idx < 0 || idx >= NREGS) return 16'h0000;
      return model[idx];
   endfunction

   function automatic logic [31:0] exp_read(input logic dyn, input int addr);
      if (!dyn) return {16'h0000, model_get(reg_index(1'b0, addr, 0))};
      return {model_get(reg_index(1'b1, addr, 1)), model_get(reg_index(1'b1, addr, 0))};
   endfunction

   task automatic model_write(input logic dyn, input int addr, input logic [31:0] wd, input logic [3:0] be);
      int nh = dyn ? 2 : 1;
      for (int h = 0; h < nh; h++) begin
         int idx = reg_index(dyn, addr, h);
         if (idx >= 0 && idx < NREGS)
            for (int b = 0; b < 2; b++)
               if (be[2*h + b]) model[idx][b*8 +: 8] = wd[16*h + 8*b +: 8];
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One transfer; returns read data and number of stalled cycles.
   task automatic xfer(input logic dyn, input logic is_rd, input int addr,
                       input logic [31:0] wd, input logic [3:0] be,
                       output logic [31:0] rd, output int stalls);
      @(negedge clk);
      dyn_mode = dyn;
      @(negedge clk);
      m_address = ADDR_W'(addr);
      m_read = is_rd; m_write = !is_rd;
      m_writedata = wd; m_byteenable = be;
      stalls = 0;
      #1;
      while (m_waitrequest) begin
         stalls++;
         @(negedge clk); #1;
      end
      rd = m_readdata;
      @(negedge clk);
      m_read = 1'b0; m_write = 1'b0;
      if (!is_rd) model_write(dyn, addr, wd, be);
   endtask

   task automatic do_read(input string req, input logic dyn, input int addr, input logic [3:0] be);
      logic [31:0] rd; int st;
      xfer(dyn, 1'b1, addr, 32'h0, be, rd, st);
      check(req, rd, exp_read(dyn, addr));
      check("R6 read stall", 32'(st), dyn ? 32'd3 : 32'd2);
   endtask

   task automatic do_write(input string req, input logic dyn, input int addr, input logic [31:0] wd, input logic [3:0] be);
      logic [31:0] rd; int st;
      xfer(dyn, 1'b0, addr, wd, be, rd, st);
      check({req, " write stall (R6)"}, 32'(st), dyn ? 32'd3 : 32'd2);
   endtask

   task automatic sweep(input string req);
      for (int w = 0; w < NREGS; w++) do_read(req, 1'b0, BASE + 4 * w, 4'hF);
   endtask

   initial begin : p_watchdog
      #400000;
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : p_main
      logic [31:0] rd; int st;
      void'($urandom(32'd2024));
      for (int i = 0; i < NREGS; i++) model[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R10 idle waitrequest", {31'h0, m_waitrequest}, 32'h0);
      sweep("R10 reset value");

      // R2/R3 native write then read; upper data ignored
      do_write("R3", 1'b0, BASE + 8, 32'hDEAD_1234, 4'hF);
      do_read("R2 native read", 1'b0, BASE + 8, 4'hF);
      do_write("R3", 1'b0, BASE + 8, 32'hFFFF_5678, 4'b1100);
      do_read("R3 upper enables ignored", 1'b0, BASE + 8, 4'hF);
      do_write("R3", 1'b0, BASE + 8, 32'h0000_AB99, 4'b0001);
      do_read("R3 single byte", 1'b0, BASE + 8, 4'hF);
      // R9 reads ignore byte enables
      do_read("R9 read with be=0", 1'b0, BASE + 8, 4'h0);

      // R5/R4 dynamic mode
      do_write("R5", 1'b1, BASE + 4, 32'hBEEF_CAFE, 4'hF);
      do_read("R4 dynamic read", 1'b1, BASE + 4, 4'hF);
      do_write("R5", 1'b1, BASE + 4, 32'h1122_3344, 4'b1001);
      do_read("R5 partial bytes", 1'b1, BASE + 4, 4'b0000);
      do_write("R5", 1'b1, BASE + 4, 32'h5566_7788, 4'b1100);
      do_read("R5 high half only", 1'b1, BASE + 4, 4'hF);
      sweep("R4 native view after dynamic writes");

      // R7 empty byte enables
      do_write("R7", 1'b0, BASE + 12, 32'hFFFF_FFFF, 4'h0);
      do_write("R7", 1'b1, BASE + 12, 32'hFFFF_FFFF, 4'h0);
      sweep("R7 no change after empty writes");

      // R8 / R4 range edges: word 5 dynamic -> regs 10 and 11 (11 out of range)
      do_write("R8", 1'b1, BASE + 20, 32'hAAAA_5A5A, 4'hF);
      do_read("R4 half out of range", 1'b1, BASE + 20, 4'hF);
      do_write("R8", 1'b0, BASE + 4 * NREGS, 32'h0000_7777, 4'hF);
      do_write("R8", 1'b0, BASE - 4, 32'h0000_6666, 4'hF);
      do_write("R8", 1'b1, BASE + 4 * 9, 32'h4444_4444, 4'hF);
      do_read("R8 out of range read", 1'b0, BASE + 4 * NREGS, 4'hF);
      do_read("R8 below base (R1)", 1'b0, BASE - 8, 4'hF);
      do_read("R8 dynamic beyond end", 1'b1, BASE + 4 * 9, 4'hF);
      sweep("R8 bank intact");

      // Random mix (R1..R9)
      for (int n = 0; n < 400; n++) begin
         logic dyn = 1'($urandom);
         int w = int'($urandom % 16) - 2;
         int addr = BASE + 4 * w;
         logic [31:0] wd = $urandom;
         logic [3:0] be = 4'($urandom);
         if ($urandom % 2) do_read("R1 random read", dyn, addr, be);
         else do_write("R5 random", dyn, addr, wd, be);
      end
      sweep("R3 final bank");

      xfer(1'b0, 1'b1, BASE, 32'h0, 4'hF, rd, st);
      #1;
      check("R10 idle after transfer", {31'h0, m_waitrequest}, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule